// File: doc/BRIEF.md
# Event Timer Register Block

This block is the register front end of a system event timer. It answers 32-bit reads and writes inside a 1 KB memory-mapped window and owns a free-running 64-bit main counter. The counter advances on each tick-enable pulse, but only while software has set the global enable bit in the configuration register. Software describes the timer through a fixed capabilities word and a read-only tick period word.

Comparator channels live outside this block. Each channel owns a 32-byte register slot in the upper part of the window. The block decodes that slot and passes the access on through a channel-select, word-offset and strobe interface. It returns the channel's read data on the bus. Each channel can raise a level match event. That event sets the channel's bit in a shared interrupt status register, and software clears the bit by writing a 1 to it.

The main counter is read and written as two 32-bit halves. Software may load it only while the global enable is clear, so a running count cannot be corrupted by a write.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the main counter, the configuration register and the status register are zero, and `glb_en` and `legacy_route` are low.
- R2: Offset 0x0 reads the capabilities word as follows, and all of its other bits read 0:
  - bits 7:0 read 0x01;
  - bits 12:8 read NUM_CH-1;
  - bit 13 reads 1 (64-bit counter);
  - bit 15 reads LEG_CAP.
- R3: Offset 0x4 reads the TICK_FS parameter. Writes to offsets 0x0 and 0x4 are ignored.
- R4: Configuration bits 1:0 at offset 0x10 are read/write. Bit 0 drives `glb_en` and bit 1 drives `legacy_route`, and the other bits read 0.
- R5: While `glb_en` is high, the main counter increments by one at each clock edge where `tick_en` is high. It holds its value at every other edge where it is not written.
- R6: The counter's low half is at offset 0xF0 and its high half at 0xF4. Writes to either half take effect only while `glb_en` is low and are ignored while it is high.
- R7: A carry out of the low half increments the high half, so the counter counts as one 64-bit value.
- R8: Status bit i at offset 0x20 is set at any clock edge where `ch_match[i]` is high. Writing a 1 clears it, writing a 0 leaves it unchanged, and a match in the same cycle as a clearing write leaves it set.
- R9: An access to 0x100 + 0x20*n + 4*k with n < NUM_CH and k < 4 raises `ch_wr`/`ch_rd` with the bus strobe. It drives `ch_sel` = n, `ch_off` = k and `ch_wdata` = `bus_wdata`, and a read returns `ch_rdata`.
- R10: All other offsets read 0 and ignore writes. This covers offsets +0x10 to +0x1C inside a channel slot, slots at or beyond NUM_CH, and reserved words. No channel strobe is raised for these offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick pulse |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address in the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, else 0 |
| ch_match | input | NUM_CH | Per-channel level match events |
| ch_rdata | input | 32 | Read data from the selected channel |
| ch_wr | output | 1 | Channel write strobe |
| ch_rd | output | 1 | Channel read strobe |
| ch_sel | output | SW | Selected channel |
| ch_off | output | 2 | Word offset within the channel slot |
| ch_wdata | output | 32 | Write data to the channel |
| glb_en | output | 1 | Global enable (configuration bit 0) |
| legacy_route | output | 1 | Legacy routing select (configuration bit 1) |
| main_count | output | 64 | Current main counter value |

## Verification
The assertions check four things on every cycle:
- counter stepping and holding, including that a counter write cannot take effect while enabled;
- sticky status bits;
- that a channel strobe is always raised under the matching bus strobe;
- that a channel strobe is never raised for the reserved upper half of a slot.

Only the bench scenarios can show the following:
- the exact values of the capabilities and period words;
- the carry from the low half into the high half;
- the set-over-clear rule for status bits;
- that writes to read-only and unmapped offsets leave the readable state untouched.

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int NUM_CH = 3,
  parameter logic [31:0] TICK_FS = 32'h0098_9680,
  parameter bit LEG_CAP = 1'b1,
  localparam int SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [9:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ch_match,
  input  logic [31:0]       ch_rdata,
  output logic              ch_wr,
  output logic              ch_rd,
  output logic [SW-1:0]     ch_sel,
  output logic [1:0]        ch_off,
  output logic [31:0]       ch_wdata,
  output logic              glb_en,
  output logic              legacy_route,
  output logic [63:0]       main_count
);
  localparam logic [7:0] W_CAP = 8'h00, W_PER = 8'h01, W_CFG = 8'h04,
                         W_STS = 8'h08, W_CLO = 8'h3C, W_CHI = 8'h3D;
  localparam logic [4:0] NCH_M1 = 5'(NUM_CH - 1);
  localparam logic [31:0] CAP_WORD = {16'h0, LEG_CAP, 1'b0, 1'b1, NCH_M1, 8'h01};

  logic [1:0]        cfg;
  logic [NUM_CH-1:0] sts;
  logic [63:0]       cnt;
  logic [7:0]        wa;
  logic [4:0]        chi;
  logic              in_ch;
  logic [31:0]       rmux;

  assign wa    = bus_addr[9:2];
  assign chi   = bus_addr[9:5] - 5'd8;
  assign in_ch = bus_addr[9:8] != 2'b00 && !bus_addr[4] && int'(chi) < NUM_CH;

  assign ch_wr    = bus_wr && in_ch;
  assign ch_rd    = bus_rd && in_ch;
  assign ch_sel   = chi[SW-1:0];
  assign ch_off   = bus_addr[3:2];
  assign ch_wdata = bus_wdata;

  assign glb_en       = cfg[0];
  assign legacy_route = cfg[1];
  assign main_count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      sts <= '0;
      cnt <= '0;
    end else begin
      if (bus_wr && wa == W_CFG) cfg <= bus_wdata[1:0];
      sts <= (sts & ~((bus_wr && wa == W_STS) ? bus_wdata[NUM_CH-1:0] : '0)) | ch_match;
      if (!cfg[0] && bus_wr && wa == W_CLO)      cnt[31:0]  <= bus_wdata;
      else if (!cfg[0] && bus_wr && wa == W_CHI) cnt[63:32] <= bus_wdata;
      else if (cfg[0] && tick_en)                cnt <= cnt + 64'd1;
    end
  end

  always_comb begin
    rmux = '0;
    if (in_ch) rmux = ch_rdata;
    else begin
      case (wa)
        W_CAP: rmux = CAP_WORD;
        W_PER: rmux = TICK_FS;
        W_CFG: rmux = {30'h0, cfg};
        W_STS: rmux[NUM_CH-1:0] = sts;
        W_CLO: rmux = cnt[31:0];
        W_CHI: rmux = cnt[63:32];
        default: rmux = '0;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rmux : '0;
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [9:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_CH-1:0] ch_match,
  input logic              ch_wr,
  input logic              ch_rd,
  input logic              glb_en,
  input logic [63:0]       main_count,
  input logic [NUM_CH-1:0] sts
);
  logic cnt_wr_try;
  assign cnt_wr_try = bus_wr && bus_addr[9:3] == 7'h1E;

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick_en) |=> main_count == $past(main_count) + 64'd1);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr_try) |=> $stable(main_count));

  // R6
  cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !tick_en && cnt_wr_try) |=> $stable(main_count));

  // R9
  ch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr |-> bus_wr) and (ch_rd |-> bus_rd));

  // R10
  ch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[4] |-> !(ch_wr || ch_rd));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sts
    // R8
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_match[i] |=> sts[i]);
    // R8
    sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(bus_wr && bus_addr[9:2] == 8'h08 && bus_wdata[i])) |=> sts[i]);
  end
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_evt_timer_regs.sv
module test_evt_timer_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam logic [31:0] TICK_FS = 32'h0098_9680;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0, bus_rd = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, ch_rdata, ch_wdata;
  logic [NUM_CH-1:0] ch_match = '0;
  logic ch_wr, ch_rd, glb_en, legacy_route;
  logic [SW-1:0] ch_sel;
  logic [1:0] ch_off;
  logic [63:0] main_count;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit chrd_q[$];
  logic [SW-1:0] last_sel;
  logic [1:0] last_off;
  logic [31:0] last_data;
  int chw_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ch_rdata = 32'hC0DE_0000 | (32'(ch_sel) << 8) | 32'(ch_off);

  evt_timer_regs #(.NUM_CH(NUM_CH), .TICK_FS(TICK_FS), .LEG_CAP(1'b1)) i_evt_timer_regs (.*);

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ch_wr) begin
      last_sel = ch_sel; last_off = ch_off; last_data = ch_wdata; chw_seen++;
    end
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual read with empty queue expected none");
      end else begin
        logic [31:0] e;
        string t;
        bit c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = chrd_q.pop_front();
        chk(bus_rdata, e, t);
        chk(32'(ch_rd), 32'(c), {t, " ch_rd"});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic rd(logic [9:0] a, logic [31:0] e, string tag, bit c = 0);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(tag); chrd_q.push_back(c);
    @(posedge clk); #2;
    bus_rd = 0;
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #2;
    bus_wr = 0;
  endtask

  task automatic ticks(int n);
    @(posedge clk); #2;
    tick_en = 1;
    repeat (n) @(posedge clk);
    #2 tick_en = 0;
  endtask

  task automatic pulse(logic [NUM_CH-1:0] m);
    @(posedge clk); #2;
    ch_match = m;
    @(posedge clk); #2;
    ch_match = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1
    chk(32'(glb_en), 0, "R1 glb_en");
    chk(32'(legacy_route), 0, "R1 legacy_route");
    rd(10'h0F0, 0, "R1 count low");
    rd(10'h0F4, 0, "R1 count high");
    rd(10'h010, 0, "R1 cfg");
    rd(10'h020, 0, "R1 status");
    // R2 R3
    rd(10'h000, 32'h0000_A201, "R2 capabilities");
    rd(10'h004, TICK_FS, "R3 period");
    wr(10'h000, 32'hFFFF_FFFF);
    wr(10'h004, 32'h1234_5678);
    rd(10'h000, 32'h0000_A201, "R3 capabilities after write");
    rd(10'h004, TICK_FS, "R3 period after write");
    // R4
    wr(10'h010, 32'hFFFF_FFFE);
    rd(10'h010, 32'h2, "R4 cfg readback");
    chk(32'(legacy_route), 1, "R4 legacy_route");
    chk(32'(glb_en), 0, "R4 glb_en");
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, 0, "R10 reserved cfg high");
    rd(10'h010, 32'h2, "R10 cfg after reserved write");
    wr(10'h010, 0);
    // R6 load while disabled
    wr(10'h0F0, 32'hFFFF_FFFE);
    wr(10'h0F4, 0);
    rd(10'h0F0, 32'hFFFF_FFFE, "R6 load low");
    rd(10'h0F4, 0, "R6 load high");
    // R5 hold while disabled
    ticks(3);
    rd(10'h0F0, 32'hFFFF_FFFE, "R5 hold when disabled");
    // R5 R7 count with carry
    wr(10'h010, 1);
    chk(32'(glb_en), 1, "R4 glb_en set");
    ticks(3);
    wr(10'h010, 0);
    rd(10'h0F0, 32'h1, "R7 low after carry");
    rd(10'h0F4, 32'h1, "R7 high after carry");
    chk(main_count[31:0], 32'h1, "R5 main_count low");
    // R6 writes ignored while enabled
    wr(10'h010, 1);
    wr(10'h0F0, 32'h1234);
    wr(10'h0F4, 32'h99);
    wr(10'h010, 0);
    rd(10'h0F0, 32'h1, "R6 low locked");
    rd(10'h0F4, 32'h1, "R6 high locked");
    // R8 status
    pulse(3'b010);
    rd(10'h020, 32'h2, "R8 status set");
    wr(10'h020, 0);
    rd(10'h020, 32'h2, "R8 write zero keeps");
    wr(10'h020, 32'h2);
    rd(10'h020, 0, "R8 write one clears");
    pulse(3'b001);
    @(posedge clk); #2;
    bus_addr = 10'h020; bus_wdata = 32'h1; bus_wr = 1; ch_match = 3'b001;
    @(posedge clk); #2;
    bus_wr = 0; ch_match = '0;
    rd(10'h020, 32'h1, "R8 set wins over clear");
    // R9 channel forwarding
    rd(10'h148, 32'hC0DE_0202, "R9 channel 2 word 2", 1);
    rd(10'h100, 32'hC0DE_0000, "R9 channel 0 word 0", 1);
    wr(10'h124, 32'h0000_55AA);
    chk(32'(chw_seen), 1, "R9 channel write count");
    chk(32'(last_sel), 1, "R9 write select");
    chk(32'(last_off), 1, "R9 write offset");
    chk(last_data, 32'h55AA, "R9 write data");
    // R10 unmapped
    rd(10'h008, 0, "R10 reserved 0x8");
    rd(10'h030, 0, "R10 reserved 0x30");
    rd(10'h110, 0, "R10 slot upper half");
    rd(10'h160, 0, "R10 slot beyond channels");
    wr(10'h170, 32'hFFFF_FFFF);
    wr(10'h118, 32'hFFFF_FFFF);
    chk(32'(chw_seen), 1, "R10 no channel strobe");
    repeat (3) @(posedge clk);
    chk(32'(exp_q.size()), 0, "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule